// File: doc/BRIEF.md
# Layered EEPROM Write-Protection Controller

This block sits beside the controller of a 256-byte serial memory and decides, for every byte that is about to be committed, whether the write may proceed. Three sources of protection are combined: a one-way software lock, a software lock that can be set and cleared again, and an external protect pin. Both software locks guard only the lower half of the array (word addresses 0 to 127). The pin guards the whole array whatever the software locks hold. Between them, the array can be left open, protected in its first half, or protected entirely.

A serial front end decodes the special lock commands and hands each one over as a single-cycle strobe with a 2-bit operation code. The block replies one cycle later with an acknowledge or a refusal. Lock status is reported through that reply and not through returned data, so the reversible-lock query carries no payload. The two lock flags model non-volatile cells in flip-flops. A reset returns them to a parameterised initial value, which is unprogrammed by default, so that simulations start clean. The memory controller presents the target address on a separate port and reads back a combinational permit in the same cycle. If the protect pin is not connected, a pull-down at the pad is expected to hold it low.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset, with default parameters, both locks are unprogrammed, `resp_valid_o` is low and every address is writable while `hw_protect_i` is low.
- R2: While either software lock is programmed and `hw_protect_i` is low, addresses 0 to 127 are not writable and addresses 128 to 255 are writable.
- R3: Operation code 2'b00 programs the permanent lock and is acknowledged if that lock was clear. If it was already set, the command is refused. No command ever clears the permanent lock.
- R4: Operation code 2'b01 programs the reversible lock and is acknowledged when both locks are clear. If the reversible lock is already set, the command is refused and the state stays as it is.
- R5: Operation code 2'b10 clears the reversible lock and is acknowledged while the permanent lock is clear, including when the reversible lock was already clear.
- R6: While the permanent lock is set, codes 2'b01 and 2'b10 are refused and leave the reversible lock unchanged.
- R7: Operation code 2'b11 is a status query. It changes no state and is acknowledged when the reversible lock is clear and refused when it is set.
- R8: While `hw_protect_i` is high, no address is writable, whatever the software locks hold. While it is low, the pin has no effect.
- R9: A command sampled with `cmd_valid_i` high at a rising edge gives exactly one cycle of `resp_valid_o` after that edge. `resp_ack_o` is 1 for acknowledge and 0 for refusal. The new lock state is visible on `wr_allow_o` from that same edge.
- R10: While `cmd_valid_i` is low, `cmd_op_i` is ignored: no response is produced and no lock changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_protect_i | input | 1 | External protect pin, high protects the whole array |
| cmd_valid_i | input | 1 | Single-cycle strobe for a decoded lock command |
| cmd_op_i | input | 2 | Operation: 00 set permanent, 01 set reversible, 10 clear reversible, 11 query reversible |
| resp_valid_o | output | 1 | Reply present, one cycle after the command |
| resp_ack_o | output | 1 | 1 = acknowledge, 0 = refusal |
| wr_addr_i | input | 8 | Word address of the pending write |
| wr_allow_o | output | 1 | Combinational write permit for `wr_addr_i` |

## Verification
A command is driven at a falling edge and taken at the next rising edge. The bench reads the reply just after that edge, and then reads `resp_valid_o` again after the following edge to confirm the reply lasts a single cycle. The write permit has no register on its path. Each permit probe therefore sets the address, waits a short settling delay inside the same cycle and samples, and lock changes are probed only after the edge that took the command. Pin effects are checked in the same way, with no clock edge between driving `hw_protect_i` and sampling.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    OP_SET_PERM  = 2'b00,
    OP_SET_REV   = 2'b01,
    OP_CLR_REV   = 2'b10,
    OP_QUERY_REV = 2'b11
  } wp_op_e;
endpackage

// File: rtl/wp_lock_regs.sv
module wp_lock_regs #(
  parameter bit PERM_INIT = 1'b0,
  parameter bit REV_INIT  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic perm_set_i,
  input  logic rev_set_i,
  input  logic rev_clr_i,
  output logic perm_o,
  output logic rev_o
);
  logic perm_q, rev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perm_q <= PERM_INIT;
      rev_q  <= REV_INIT;
    end else begin
      if (perm_set_i) perm_q <= 1'b1;  // one-way: no clear path exists
      if (rev_set_i)      rev_q <= 1'b1;
      else if (rev_clr_i) rev_q <= 1'b0;
    end
  end

  assign perm_o = perm_q;
  assign rev_o  = rev_q;

  assert_perm_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_q |=> perm_q);

  assert_rev_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_q |=> $stable(rev_q));
endmodule

// File: rtl/wp_cmd_unit.sv
module wp_cmd_unit
  import wp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_valid_i,
  input  wp_op_e cmd_op_i,
  input  logic   perm_i,
  input  logic   rev_i,
  output logic   perm_set_o,
  output logic   rev_set_o,
  output logic   rev_clr_o,
  output logic   resp_valid_o,
  output logic   resp_ack_o
);
  logic ack_d;
  logic resp_valid_q, resp_ack_q;

  always_comb begin
    ack_d      = 1'b0;
    perm_set_o = 1'b0;
    rev_set_o  = 1'b0;
    rev_clr_o  = 1'b0;
    unique case (cmd_op_i)
      OP_SET_PERM: begin
        ack_d      = !perm_i;
        perm_set_o = cmd_valid_i && ack_d;
      end
      OP_SET_REV: begin
        ack_d     = !perm_i && !rev_i;
        rev_set_o = cmd_valid_i && ack_d;
      end
      OP_CLR_REV: begin
        ack_d     = !perm_i;
        rev_clr_o = cmd_valid_i && ack_d;
      end
      OP_QUERY_REV: ack_d = !rev_i;  // status only, no update
      default: ack_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_ack_q   <= 1'b0;
    end else begin
      resp_valid_q <= cmd_valid_i;
      resp_ack_q   <= cmd_valid_i && ack_d;
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_ack_o   = resp_ack_q;

  assert_query_reply_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_QUERY_REV) |=> (resp_valid_o && (resp_ack_o == !$past(rev_i))));

  assert_locked_refuse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && perm_i && (cmd_op_i == OP_SET_REV || cmd_op_i == OP_CLR_REV))
      |=> (resp_valid_o && !resp_ack_o));

  assert_no_spurious_resp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !resp_valid_o);
endmodule

// File: rtl/wp_allow_eval.sv
module wp_allow_eval #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hw_protect_i,
  input  logic              perm_i,
  input  logic              rev_i,
  output logic              allow_o
);
  localparam logic [ADDR_W-1:0] HalfBase = {1'b1, {(ADDR_W-1){1'b0}}};

  logic in_low_half;
  assign in_low_half = addr_i < HalfBase;
  assign allow_o = !hw_protect_i && !(in_low_half && (perm_i || rev_i));
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter bit PERM_INIT = 1'b0,
  parameter bit REV_INIT  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_protect_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  output logic              resp_valid_o,
  output logic              resp_ack_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              wr_allow_o
);
  logic perm, rev;
  logic perm_set, rev_set, rev_clr;

  wp_cmd_unit u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (wp_op_e'(cmd_op_i)),
    .perm_i       (perm),
    .rev_i        (rev),
    .perm_set_o   (perm_set),
    .rev_set_o    (rev_set),
    .rev_clr_o    (rev_clr),
    .resp_valid_o (resp_valid_o),
    .resp_ack_o   (resp_ack_o)
  );

  wp_lock_regs #(
    .PERM_INIT (PERM_INIT),
    .REV_INIT  (REV_INIT)
  ) u_locks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .perm_set_i (perm_set),
    .rev_set_i  (rev_set),
    .rev_clr_i  (rev_clr),
    .perm_o     (perm),
    .rev_o      (rev)
  );

  wp_allow_eval #(.ADDR_W(ADDR_W)) u_allow (
    .addr_i       (wr_addr_i),
    .hw_protect_i (hw_protect_i),
    .perm_i       (perm),
    .rev_i        (rev),
    .allow_o      (wr_allow_o)
  );

  assert_hw_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_protect_i |-> !wr_allow_o);

  assert_upper_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_protect_i && wr_addr_i[ADDR_W-1]) |-> wr_allow_o);

  assert_resp_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> (!resp_valid_o || $past(cmd_valid_i)));
endmodule

// File: tb/eeprom_wp_ctrl_tb.sv
module eeprom_wp_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw = 1'b0;
  logic       cv = 1'b0;
  logic [1:0] op = 2'b00;
  logic       rv, ra, allow;
  logic [7:0] addr = 8'd0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [1:0] SetPerm = 2'b00, SetRev = 2'b01, ClrRev = 2'b10, QryRev = 2'b11;

  always #2.5 clk = ~clk;  // 200 MHz

  eeprom_wp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_protect_i(hw), .cmd_valid_i(cv), .cmd_op_i(op),
    .resp_valid_o(rv), .resp_ack_o(ra), .wr_addr_i(addr), .wr_allow_o(allow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] o, input logic exp_ack, input string req);
    @(negedge clk);
    cv = 1'b1; op = o;
    @(posedge clk); #1;
    chk(rv == 1'b1, "R9", {req, " reply valid"}, 32'(rv), 1);
    chk(ra == exp_ack, req, "reply ack", 32'(ra), 32'(exp_ack));
    @(negedge clk);
    cv = 1'b0;
    @(posedge clk); #1;
    chk(rv == 1'b0, "R9", "reply lasts one cycle", 32'(rv), 0);
  endtask

  task automatic probe(input logic [7:0] a, input logic exp, input string req);
    addr = a; #1;
    chk(allow == exp, req, $sformatf("allow at %0d", a), 32'(allow), 32'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cv = 1'b0; hw = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(rv == 1'b0, "R1", "resp_valid after reset", 32'(rv), 0);
    probe(8'd0, 1'b1, "R1");
    probe(8'd127, 1'b1, "R1");
    probe(8'd255, 1'b1, "R1");
  endtask

  task automatic t_hw_pin();
    hw = 1'b1;
    probe(8'd0, 1'b0, "R8");
    probe(8'd128, 1'b0, "R8");
    probe(8'd255, 1'b0, "R8");
    hw = 1'b0;
    probe(8'd200, 1'b1, "R8");
    probe(8'd5, 1'b1, "R8");
  endtask

  task automatic t_rev_cycle();
    send_cmd(QryRev, 1'b1, "R7");
    send_cmd(SetRev, 1'b1, "R4");
    probe(8'd0, 1'b0, "R2");
    probe(8'd127, 1'b0, "R2");
    probe(8'd128, 1'b1, "R2");
    probe(8'd255, 1'b1, "R2");
    send_cmd(SetRev, 1'b0, "R4");
    send_cmd(QryRev, 1'b0, "R7");
    probe(8'd64, 1'b0, "R7");
    send_cmd(ClrRev, 1'b1, "R5");
    probe(8'd0, 1'b1, "R5");
    send_cmd(ClrRev, 1'b1, "R5");
    send_cmd(QryRev, 1'b1, "R5");
  endtask

  task automatic t_idle_ignored();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op = 2'(i);
      @(posedge clk); #1;
      chk(rv == 1'b0, "R10", "no reply while idle", 32'(rv), 0);
    end
    probe(8'd10, 1'b1, "R10");
    send_cmd(QryRev, 1'b1, "R10");
    send_cmd(SetPerm, 1'b1, "R10");
  endtask

  task automatic t_perm_alone();
    do_reset();
    send_cmd(SetPerm, 1'b1, "R3");
    probe(8'd100, 1'b0, "R3");
    probe(8'd130, 1'b1, "R2");
    send_cmd(SetRev, 1'b0, "R6");
    send_cmd(QryRev, 1'b1, "R6");
    send_cmd(ClrRev, 1'b0, "R6");
    send_cmd(SetPerm, 1'b0, "R3");
    probe(8'd0, 1'b0, "R3");
  endtask

  task automatic t_perm_with_rev();
    do_reset();
    send_cmd(SetRev, 1'b1, "R4");
    send_cmd(SetPerm, 1'b1, "R3");
    send_cmd(ClrRev, 1'b0, "R6");
    send_cmd(QryRev, 1'b0, "R6");
    probe(8'd1, 1'b0, "R6");
    hw = 1'b1;
    probe(8'd250, 1'b0, "R8");
    hw = 1'b0;
    probe(8'd250, 1'b1, "R8");
  endtask

  initial begin
    t_reset();
    t_hw_pin();
    t_rev_cycle();
    t_idle_ignored();
    t_perm_alone();
    t_perm_with_rev();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule